// File: doc/BRIEF.md
# Flash Page-Region Access Checker

This block sits in front of a paged flash controller and rules on every read, program or erase request before it reaches the array. It holds eight protection regions. Each region has a base page, a length in pages, its own enable bit, and a set of permission and attribute fields. It also holds one default policy with the same fields. Page numbers are global across the two banks: bank 0 covers pages 0 to 255 and bank 1 starts at page 256.

For each request the block finds every enabled region that contains the page. The region with the lowest index wins. If no region contains the page, the default policy applies. The block then checks the requested operation against the winning permission field. It answers with allow or error, the index of the matching region (or an indication that the default policy applied), and the scramble, ECC and high-endurance attribute codes of that entry. These attribute codes are passed out unchanged and are not acted on.

Configuration is written with a one-cycle strobe. Requests and responses each use a valid/ready handshake. A request is accepted when `req_valid` and `req_ready` are both high at a rising edge. `req_ready` is low only while a response is waiting and `rsp_ready` is low. A waiting response holds its value until `rsp_ready` is sampled high.

Top module: `flash_mp_checker`

## Requirements
- R1: A region covers pages base through base+size-1. A region whose size is 0 covers no page.
- R2: When more than one enabled region contains the page, the one with the lowest index decides the result and is reported in `rsp_region`.
- R3: Writing with `cfg_field`=1 sets only a region's enable bit. A disabled region never matches. Turning the enable off and back on keeps the region's base, size and fields.
- R4: A page matched by no enabled region is judged by the default policy, which is written with `cfg_target`=8 and `cfg_field`=0. Such a response has `rsp_hit`=0 and `rsp_region`=0.
- R5: `req_op` is encoded as 00 read, 01 program, 10 erase. Each operation is judged by its own permission field. A permitted request gives `rsp_allow`=1 and `rsp_err`=0. A refused one gives `rsp_allow`=0 and `rsp_err`=1. Code 11 is always refused.
- R6: A permission field is true only when it holds 4'h6, and false when it holds 4'h9. Any other value counts as false and sets `cfg_err`, which stays set until reset.
- R7: The response appears in the cycle after the request is accepted. A response that is not taken stays stable and blocks new requests. With no accepted request, a taken response clears `rsp_valid`.
- R8: When base+size runs past page 511, the region matches up to page 511 only and does not wrap to low pages.
- R9: `rsp_scramble`, `rsp_ecc` and `rsp_hiend` carry the raw 4-bit codes of the entry that decided the result.
- R10: After reset, `rsp_valid`=0, `cfg_err`=0, `req_ready`=1, every region is disabled, and every default field is 4'h9, so every operation is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_target | input | 4 | Region index 0..7, or 8 for the default policy |
| cfg_field | input | 1 | 0 writes properties, 1 writes the region enable bit |
| cfg_en | input | 1 | Enable value for a region |
| cfg_base | input | 9 | Region first page |
| cfg_size | input | 10 | Region length in pages |
| cfg_rd_en | input | 4 | Read permission code |
| cfg_prog_en | input | 4 | Program permission code |
| cfg_erase_en | input | 4 | Erase permission code |
| cfg_scramble | input | 4 | Scramble attribute code |
| cfg_ecc | input | 4 | ECC attribute code |
| cfg_hiend | input | 4 | High-endurance attribute code |
| cfg_err | output | 1 | Sticky invalid-permission-code flag |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_page | input | 9 | Global page number |
| req_op | input | 2 | Operation code |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_allow | output | 1 | Operation permitted |
| rsp_err | output | 1 | Operation refused |
| rsp_hit | output | 1 | A region matched (0 means the default policy applied) |
| rsp_region | output | 3 | Index of the matching region |
| rsp_scramble | output | 4 | Scramble code of the deciding entry |
| rsp_ecc | output | 4 | ECC code of the deciding entry |
| rsp_hiend | output | 4 | High-endurance code of the deciding entry |

## Verification
The hardest case to reach is a page that sits inside three nested regions at once, with each region granting a different set of operations. The bench builds this in bank 1 by enabling the widest region first, then a narrower one, then the innermost one. After each step it probes pages in the inner span, the outer span and at both edges. It then turns the innermost region off and on again, which shows that the enable write leaves the region's properties untouched. Back-pressure is reached by holding `rsp_ready` low while a second request waits at the input.

// File: rtl/mp_pkg.sv
package mp_pkg;
  localparam logic [3:0] MB_TRUE  = 4'h6;
  localparam logic [3:0] MB_FALSE = 4'h9;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_RSVD  = 2'b11
  } mp_op_e;

  typedef struct packed {
    logic [3:0] rd;
    logic [3:0] prog;
    logic [3:0] erase;
    logic [3:0] scr;
    logic [3:0] ecc;
    logic [3:0] he;
  } mp_attr_t;

  localparam mp_attr_t ATTR_RESET = '{MB_FALSE, MB_FALSE, MB_FALSE,
                                      MB_FALSE, MB_FALSE, MB_FALSE};

  function automatic logic mb_true(input logic [3:0] v);
    return v == MB_TRUE;
  endfunction

  function automatic logic mb_legal(input logic [3:0] v);
    return (v == MB_TRUE) || (v == MB_FALSE);
  endfunction
endpackage

// File: rtl/mp_region_match.sv
module mp_region_match #(
  parameter int PAGE_W = 9
) (
  input  logic              en,
  input  logic [PAGE_W-1:0] base,
  input  logic [PAGE_W:0]   size,
  input  logic [PAGE_W-1:0] page,
  output logic              hit
);
  localparam int EXT_W = PAGE_W + 2;

  logic [EXT_W-1:0] lo, hi, pg;

  assign lo  = EXT_W'(base);
  assign hi  = lo + EXT_W'(size);
  assign pg  = EXT_W'(page);
  assign hit = en && (pg >= lo) && (pg < hi);
endmodule

// File: rtl/mp_prio_pick.sv
module mp_prio_pick #(
  parameter int NUM   = 8,
  parameter int IDX_W = 3
) (
  input  logic [NUM-1:0]   hits,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |hits;
    idx = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (hits[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/mp_perm_eval.sv
module mp_perm_eval
  import mp_pkg::*;
(
  input  mp_attr_t   attr,
  input  logic [1:0] op,
  output logic       ok
);
  always_comb begin
    case (mp_op_e'(op))
      OP_READ:  ok = mb_true(attr.rd);
      OP_PROG:  ok = mb_true(attr.prog);
      OP_ERASE: ok = mb_true(attr.erase);
      default:  ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/flash_mp_checker.sv
module flash_mp_checker
  import mp_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int PAGE_W      = 9,
  localparam int IDX_W      = $clog2(NUM_REGIONS),
  localparam int TGT_W      = $clog2(NUM_REGIONS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [TGT_W-1:0]  cfg_target,
  input  logic              cfg_field,
  input  logic              cfg_en,
  input  logic [PAGE_W-1:0] cfg_base,
  input  logic [PAGE_W:0]   cfg_size,
  input  logic [3:0]        cfg_rd_en,
  input  logic [3:0]        cfg_prog_en,
  input  logic [3:0]        cfg_erase_en,
  input  logic [3:0]        cfg_scramble,
  input  logic [3:0]        cfg_ecc,
  input  logic [3:0]        cfg_hiend,
  output logic              cfg_err,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [1:0]        req_op,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_allow,
  output logic              rsp_err,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_region,
  output logic [3:0]        rsp_scramble,
  output logic [3:0]        rsp_ecc,
  output logic [3:0]        rsp_hiend
);
  localparam logic [TGT_W-1:0] DFLT_TGT = TGT_W'(NUM_REGIONS);

  logic              reg_en   [NUM_REGIONS];
  logic [PAGE_W-1:0] reg_base [NUM_REGIONS];
  logic [PAGE_W:0]   reg_size [NUM_REGIONS];
  mp_attr_t          reg_attr [NUM_REGIONS];
  mp_attr_t          dflt_attr;

  mp_attr_t wr_attr;
  logic     wr_bad, is_region, is_dflt;

  assign wr_attr   = '{cfg_rd_en, cfg_prog_en, cfg_erase_en,
                       cfg_scramble, cfg_ecc, cfg_hiend};
  assign wr_bad    = !(mb_legal(cfg_rd_en) && mb_legal(cfg_prog_en) &&
                       mb_legal(cfg_erase_en));
  assign is_region = cfg_target < DFLT_TGT;
  assign is_dflt   = cfg_target == DFLT_TGT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGIONS; i++) begin
        reg_en[i]   <= 1'b0;
        reg_base[i] <= '0;
        reg_size[i] <= '0;
        reg_attr[i] <= ATTR_RESET;
      end
      dflt_attr <= ATTR_RESET;
      cfg_err   <= 1'b0;
    end else if (cfg_wr) begin
      if (is_region && cfg_field) begin
        reg_en[cfg_target[IDX_W-1:0]] <= cfg_en;
      end else if (is_region) begin
        reg_base[cfg_target[IDX_W-1:0]] <= cfg_base;
        reg_size[cfg_target[IDX_W-1:0]] <= cfg_size;
        reg_attr[cfg_target[IDX_W-1:0]] <= wr_attr;
        if (wr_bad) cfg_err <= 1'b1;
      end else if (is_dflt && !cfg_field) begin
        dflt_attr <= wr_attr;
        if (wr_bad) cfg_err <= 1'b1;
      end
    end
  end

  logic [NUM_REGIONS-1:0] hits;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
    mp_region_match #(.PAGE_W(PAGE_W)) u_match (
      .en  (reg_en[g]),
      .base(reg_base[g]),
      .size(reg_size[g]),
      .page(req_page),
      .hit (hits[g])
    );
  end

  logic             any_hit;
  logic [IDX_W-1:0] win_idx;
  mp_attr_t         gov;
  logic             op_ok;

  mp_prio_pick #(.NUM(NUM_REGIONS), .IDX_W(IDX_W)) u_pick (
    .hits(hits),
    .any (any_hit),
    .idx (win_idx)
  );

  assign gov = any_hit ? reg_attr[win_idx] : dflt_attr;

  mp_perm_eval u_eval (
    .attr(gov),
    .op  (req_op),
    .ok  (op_ok)
  );

  logic accept;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_allow    <= 1'b0;
      rsp_err      <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_region   <= '0;
      rsp_scramble <= MB_FALSE;
      rsp_ecc      <= MB_FALSE;
      rsp_hiend    <= MB_FALSE;
    end else if (accept) begin
      rsp_valid    <= 1'b1;
      rsp_allow    <= op_ok;
      rsp_err      <= !op_ok;
      rsp_hit      <= any_hit;
      rsp_region   <= any_hit ? win_idx : '0;
      rsp_scramble <= gov.scr;
      rsp_ecc      <= gov.ecc;
      rsp_hiend    <= gov.he;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mp_checker_sva.sv
module mp_checker_sva #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_err,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_allow,
  input logic             rsp_err,
  input logic             rsp_hit,
  input logic [IDX_W-1:0] rsp_region
);
  // R7
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_allow) &&
                                   $stable(rsp_hit) && $stable(rsp_region)));
  // R7
  accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  // R7
  drain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_valid && req_ready) && (!rsp_valid || rsp_ready)) |=> !rsp_valid);
  // R5
  allow_xor_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_allow != rsp_err));
  // R6
  cfg_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  // R4
  default_region_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_region == '0));
endmodule

bind flash_mp_checker mp_checker_sva #(.IDX_W(IDX_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_err   (cfg_err),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_allow (rsp_allow),
  .rsp_err   (rsp_err),
  .rsp_hit   (rsp_hit),
  .rsp_region(rsp_region)
);

// File: tb/tb_flash_mp_checker.sv
module tb_flash_mp_checker;
  localparam logic [3:0] T = 4'h6;
  localparam logic [3:0] F = 4'h9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [3:0] cfg_target = '0;
  logic       cfg_field = 1'b0;
  logic       cfg_en = 1'b0;
  logic [8:0] cfg_base = '0;
  logic [9:0] cfg_size = '0;
  logic [3:0] cfg_rd_en = F, cfg_prog_en = F, cfg_erase_en = F;
  logic [3:0] cfg_scramble = F, cfg_ecc = F, cfg_hiend = F;
  logic       cfg_err;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [8:0] req_page = '0;
  logic [1:0] req_op = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic       rsp_allow, rsp_err, rsp_hit;
  logic [2:0] rsp_region;
  logic [3:0] rsp_scramble, rsp_ecc, rsp_hiend;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_mp_checker dut (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_region(input int idx, input int base, input int size,
                           input logic [3:0] rd, input logic [3:0] pg,
                           input logic [3:0] er, input logic [3:0] sc,
                           input logic [3:0] ec, input logic [3:0] he);
    @(negedge clk);
    cfg_wr = 1; cfg_target = 4'(idx); cfg_field = 0;
    cfg_base = 9'(base); cfg_size = 10'(size);
    cfg_rd_en = rd; cfg_prog_en = pg; cfg_erase_en = er;
    cfg_scramble = sc; cfg_ecc = ec; cfg_hiend = he;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic wr_enable(input int idx, input logic en);
    @(negedge clk);
    cfg_wr = 1; cfg_target = 4'(idx); cfg_field = 1; cfg_en = en;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic expect_rsp(input string req, input int page, input logic [1:0] op,
                            input logic allow, input logic hit, input int region);
    @(negedge clk);
    req_valid = 1; req_page = 9'(page); req_op = op;
    @(negedge clk);
    req_valid = 0;
    chk(req, "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(req, "rsp_allow", 32'(rsp_allow), 32'(allow));
    chk(req, "rsp_err", 32'(rsp_err), 32'(!allow));
    chk(req, "rsp_hit", 32'(rsp_hit), 32'(hit));
    chk(req, "rsp_region", 32'(rsp_region), 32'(region));
  endtask

  task automatic t_reset;
    chk("R10", "rsp_valid", 32'(rsp_valid), 0);
    chk("R10", "cfg_err", 32'(cfg_err), 0);
    chk("R10", "req_ready", 32'(req_ready), 1);
    expect_rsp("R10", 0, 2'b00, 0, 0, 0);
    expect_rsp("R10", 300, 2'b10, 0, 0, 0);
  endtask

  task automatic t_default;
    wr_region(8, 0, 0, T, T, T, T, F, T);
    expect_rsp("R4", 300, 2'b00, 1, 0, 0);
    chk("R9", "dflt scramble", 32'(rsp_scramble), 32'(T));
    chk("R9", "dflt ecc", 32'(rsp_ecc), 32'(F));
    chk("R9", "dflt hiend", 32'(rsp_hiend), 32'(T));
    expect_rsp("R5", 300, 2'b11, 0, 0, 0);
  endtask

  task automatic t_nested;
    wr_region(7, 266, 6, T, T, T, F, F, F);
    wr_enable(7, 1);
    expect_rsp("R1", 266, 2'b01, 1, 1, 7);
    expect_rsp("R1", 271, 2'b00, 1, 1, 7);
    expect_rsp("R1", 272, 2'b00, 1, 0, 0);
    expect_rsp("R1", 265, 2'b00, 1, 0, 0);
    wr_region(3, 267, 4, F, T, T, F, F, F);
    expect_rsp("R3", 268, 2'b00, 1, 1, 7);
    wr_enable(3, 1);
    expect_rsp("R2", 268, 2'b00, 0, 1, 3);
    expect_rsp("R2", 268, 2'b01, 1, 1, 3);
    expect_rsp("R2", 266, 2'b00, 1, 1, 7);
    wr_region(0, 268, 2, T, F, T, F, F, F);
    wr_enable(0, 1);
    expect_rsp("R2", 268, 2'b00, 1, 1, 0);
    expect_rsp("R5", 268, 2'b01, 0, 1, 0);
    expect_rsp("R5", 269, 2'b10, 1, 1, 0);
    expect_rsp("R2", 267, 2'b00, 0, 1, 3);
    expect_rsp("R2", 270, 2'b00, 0, 1, 3);
    wr_enable(0, 0);
    expect_rsp("R3", 268, 2'b00, 0, 1, 3);
    wr_enable(0, 1);
    expect_rsp("R3", 269, 2'b01, 0, 1, 0);
  endtask

  task automatic t_size_zero;
    wr_region(5, 100, 0, F, F, F, F, F, F);
    wr_enable(5, 1);
    expect_rsp("R1", 100, 2'b00, 1, 0, 0);
  endtask

  task automatic t_overflow;
    wr_region(6, 500, 40, T, F, F, F, F, F);
    wr_enable(6, 1);
    expect_rsp("R8", 511, 2'b00, 1, 1, 6);
    expect_rsp("R8", 511, 2'b01, 0, 1, 6);
    expect_rsp("R8", 3, 2'b01, 1, 0, 0);
  endtask

  task automatic t_attrs;
    wr_region(2, 80, 1, T, F, F, T, F, T);
    wr_enable(2, 1);
    expect_rsp("R9", 80, 2'b00, 1, 1, 2);
    chk("R9", "scramble", 32'(rsp_scramble), 32'(T));
    chk("R9", "ecc", 32'(rsp_ecc), 32'(F));
    chk("R9", "hiend", 32'(rsp_hiend), 32'(T));
  endtask

  task automatic t_mubi;
    chk("R6", "cfg_err before", 32'(cfg_err), 0);
    wr_region(1, 50, 1, 4'h5, F, T, F, F, F);
    wr_enable(1, 1);
    chk("R6", "cfg_err set", 32'(cfg_err), 1);
    expect_rsp("R6", 50, 2'b00, 0, 1, 1);
    expect_rsp("R6", 50, 2'b10, 1, 1, 1);
    wr_region(1, 50, 1, T, F, T, F, F, F);
    chk("R6", "cfg_err sticky", 32'(cfg_err), 1);
    expect_rsp("R6", 50, 2'b00, 1, 1, 1);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_page = 9'd268; req_op = 2'b00;
    @(negedge clk);
    req_page = 9'd267;
    for (int i = 0; i < 3; i++) begin
      chk("R7", "stall valid", 32'(rsp_valid), 1);
      chk("R7", "stall ready", 32'(req_ready), 0);
      chk("R7", "stall region", 32'(rsp_region), 0);
      chk("R7", "stall allow", 32'(rsp_allow), 1);
      @(negedge clk);
    end
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R7", "second valid", 32'(rsp_valid), 1);
    chk("R7", "second region", 32'(rsp_region), 3);
    chk("R7", "second allow", 32'(rsp_allow), 0);
    @(negedge clk);
    chk("R7", "drained", 32'(rsp_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_default();
    t_nested();
    t_size_zero();
    t_overflow();
    t_attrs();
    t_backpressure();
    t_mubi();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule